// File: doc/BRIEF.md
# Status-Decoding Bus Command Controller

This block sits beside a processor that announces each bus cycle through a 3-bit status code. It turns that code into separate system bus commands: memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also drives the signals that steer an external address latch and a data transceiver. A halt status produces no command.

A cycle opens when the status leaves the passive code for an active one. The block latches the code and pulses the address strobe for one clock. Read-type commands and the advanced write strobes follow in the next clock. The normal write strobes come `WR_LAG` clocks later, once write data is valid. Everything drops one clock after the status is seen passive again.

While an acknowledge reads an interrupt controller on the local bus, the transceiver enable is held off so that the transceiver does not drive the local bus against it.

Top module: `bcc_top`

## Requirements
- R1: While reset is high and on the first clock after it, every command, the address strobe and the transceiver enable are low, and the transceiver direction is high (transmit).
- R2: When the status moves from passive (111) to an active code other than halt, the address strobe is high for exactly the one clock that follows that edge.
- R3: The latched code selects one command, which goes high in the clock after the address strobe. Code 101 and code 100 select memory read, 001 selects I/O read, and 000 selects interrupt acknowledge.
- R4: Code 110 raises the advanced memory write strobe and code 010 raises the advanced I/O write strobe, in the same clock in which a read command would rise.
- R5: The normal memory or I/O write strobe rises `WR_LAG` clocks after the matching advanced strobe (default 1). It stays high while the status stays active.
- R6: The halt code 011 produces no command, no address strobe and no transceiver enable.
- R7: One clock after the status is sampled passive, every command and strobe is low. This holds even if a normal write strobe was due to rise in that clock.
- R8: At most one of memory read, memory write, I/O read, I/O write and interrupt acknowledge is high at any time.
- R9: The transceiver direction is low (receive) from the address strobe clock to the end of every read or acknowledge cycle. It is high at all other times.
- R10: For every non-halt cycle, the transceiver enable is high from the first command clock until the commands drop. The only exception is the one in R11.
- R11: During an acknowledge with the local-controller select high, the transceiver enable stays low. With the select low it behaves as in R10.
- R12: A change from one active code to another without passing through passive does not start a new cycle. The command of the latched code is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| status_i | input | 3 | Cycle status code from the processor |
| local_irqc_i | input | 1 | High when the interrupt controller sits on the local bus |
| addr_strobe_o | output | 1 | Address latch enable pulse |
| xcvr_en_o | output | 1 | Transceiver output enable |
| xcvr_tx_o | output | 1 | Transceiver direction, 1 = transmit, 0 = receive |
| mem_rd_o | output | 1 | Memory read command |
| mem_wr_o | output | 1 | Normal memory write strobe |
| mem_wr_adv_o | output | 1 | Advanced memory write strobe |
| io_rd_o | output | 1 | I/O read command |
| io_wr_o | output | 1 | Normal I/O write strobe |
| io_wr_adv_o | output | 1 | Advanced I/O write strobe |
| irq_ack_o | output | 1 | Interrupt acknowledge command |

## Verification
The return of the status to passive can arrive in the same clock in which the normal write strobe is due to rise. The bench provokes this by opening a write cycle and then driving passive while the cycle is in its early command clock. It then checks that the normal strobe never rises and that every output is idle one clock later. A second collision test drives a new active code immediately after the terminating passive clock. It checks that the release of the old cycle and the address strobe of the new one land in consecutive clocks with no overlap.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    localparam int unsigned STAT_W = 3;

    typedef enum logic [STAT_W-1:0] {
        ST_ACK     = 3'b000,
        ST_IORD    = 3'b001,
        ST_IOWR    = 3'b010,
        ST_HALT    = 3'b011,
        ST_CODE    = 3'b100,
        ST_MEMRD   = 3'b101,
        ST_MEMWR   = 3'b110,
        ST_PASSIVE = 3'b111
    } stat_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ADDR  = 2'd1,
        PH_EARLY = 2'd2,
        PH_LATE  = 2'd3
    } phase_e;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic mem_wr_adv;
        logic io_rd;
        logic io_wr;
        logic io_wr_adv;
        logic irq_ack;
    } cmd_t;

    localparam cmd_t CMD_NONE = '0;

    // Cycles in which data flows toward the processor.
    function automatic logic is_inbound(stat_e code);
        return (code == ST_ACK) || (code == ST_IORD) ||
               (code == ST_CODE) || (code == ST_MEMRD);
    endfunction

    // Codes that open a bus cycle with command activity.
    function automatic logic opens_cycle(stat_e code);
        return (code != ST_PASSIVE) && (code != ST_HALT);
    endfunction

endpackage

// File: rtl/bcc_cycle_tracker.sv
module bcc_cycle_tracker
    import bcc_pkg::*;
#(
    parameter int unsigned WR_LAG = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [STAT_W-1:0]   status_i,
    output phase_e              phase_o,
    output stat_e               code_o
);

    localparam int unsigned CNT_W = (WR_LAG > 1) ? $clog2(WR_LAG) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_LAG - 1);

    stat_e            prev_q;
    stat_e            code_q;
    stat_e            cur;
    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             start;
    logic             gone_passive;

    assign cur          = stat_e'(status_i);
    assign start        = (prev_q == ST_PASSIVE) && opens_cycle(cur);
    assign gone_passive = (cur == ST_PASSIVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= ST_PASSIVE;
            code_q  <= ST_PASSIVE;
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            prev_q <= cur;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_ADDR;
                        code_q  <= cur;
                    end
                end
                PH_ADDR: begin
                    cnt_q <= '0;
                    if (gone_passive) phase_q <= PH_IDLE;
                    else              phase_q <= PH_EARLY;
                end
                PH_EARLY: begin
                    if (gone_passive) begin
                        phase_q <= PH_IDLE;
                    end else if (cnt_q == CNT_LAST) begin
                        phase_q <= PH_LATE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_LATE: begin
                    if (gone_passive) phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign code_o  = code_q;

endmodule

// File: rtl/bcc_cmd_decoder.sv
module bcc_cmd_decoder
    import bcc_pkg::*;
(
    input  phase_e  phase_i,
    input  stat_e   code_i,
    output cmd_t    cmd_o
);

    logic active;
    logic late;

    assign active = (phase_i == PH_EARLY) || (phase_i == PH_LATE);
    assign late   = (phase_i == PH_LATE);

    always_comb begin
        cmd_o = CMD_NONE;
        if (active) begin
            unique case (code_i)
                ST_CODE,
                ST_MEMRD: cmd_o.mem_rd  = 1'b1;
                ST_IORD:  cmd_o.io_rd   = 1'b1;
                ST_ACK:   cmd_o.irq_ack = 1'b1;
                ST_MEMWR: begin
                    cmd_o.mem_wr_adv = 1'b1;
                    cmd_o.mem_wr     = late;
                end
                ST_IOWR: begin
                    cmd_o.io_wr_adv = 1'b1;
                    cmd_o.io_wr     = late;
                end
                default: cmd_o = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/bcc_xcvr_ctrl.sv
module bcc_xcvr_ctrl
    import bcc_pkg::*;
(
    input  phase_e  phase_i,
    input  stat_e   code_i,
    input  logic    local_irqc_i,
    output logic    addr_strobe_o,
    output logic    xcvr_en_o,
    output logic    xcvr_tx_o
);

    logic busy;
    logic active;
    logic local_ack;

    assign busy      = (phase_i != PH_IDLE);
    assign active    = (phase_i == PH_EARLY) || (phase_i == PH_LATE);
    assign local_ack = (code_i == ST_ACK) && local_irqc_i;

    assign addr_strobe_o = (phase_i == PH_ADDR);
    assign xcvr_en_o     = active && !local_ack;
    assign xcvr_tx_o     = !(busy && is_inbound(code_i));

endmodule

// File: rtl/bcc_top.sv
module bcc_top
    import bcc_pkg::*;
#(
    parameter int unsigned WR_LAG = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  status_i,
    input  logic        local_irqc_i,
    output logic        addr_strobe_o,
    output logic        xcvr_en_o,
    output logic        xcvr_tx_o,
    output logic        mem_rd_o,
    output logic        mem_wr_o,
    output logic        mem_wr_adv_o,
    output logic        io_rd_o,
    output logic        io_wr_o,
    output logic        io_wr_adv_o,
    output logic        irq_ack_o
);

    phase_e phase;
    stat_e  code;
    cmd_t   cmd;

    bcc_cycle_tracker #(
        .WR_LAG (WR_LAG)
    ) u_track (
        .clk      (clk),
        .rst      (rst),
        .status_i (status_i),
        .phase_o  (phase),
        .code_o   (code)
    );

    bcc_cmd_decoder u_dec (
        .phase_i (phase),
        .code_i  (code),
        .cmd_o   (cmd)
    );

    bcc_xcvr_ctrl u_xcvr (
        .phase_i       (phase),
        .code_i        (code),
        .local_irqc_i  (local_irqc_i),
        .addr_strobe_o (addr_strobe_o),
        .xcvr_en_o     (xcvr_en_o),
        .xcvr_tx_o     (xcvr_tx_o)
    );

    assign mem_rd_o     = cmd.mem_rd;
    assign mem_wr_o     = cmd.mem_wr;
    assign mem_wr_adv_o = cmd.mem_wr_adv;
    assign io_rd_o      = cmd.io_rd;
    assign io_wr_o      = cmd.io_wr;
    assign io_wr_adv_o  = cmd.io_wr_adv;
    assign irq_ack_o    = cmd.irq_ack;

endmodule

// File: rtl/bcc_checker.sv
module bcc_checker (
    input logic       clk,
    input logic       rst,
    input logic [2:0] status_i,
    input logic       local_irqc_i,
    input logic       addr_strobe_o,
    input logic       xcvr_en_o,
    input logic       xcvr_tx_o,
    input logic       mem_rd_o,
    input logic       mem_wr_o,
    input logic       mem_wr_adv_o,
    input logic       io_rd_o,
    input logic       io_wr_o,
    input logic       io_wr_adv_o,
    input logic       irq_ack_o
);

    logic [4:0] main_cmds;
    logic       any_cmd;
    logic       rd_cmd;

    assign main_cmds = {mem_rd_o, mem_wr_o, io_rd_o, io_wr_o, irq_ack_o};
    assign any_cmd   = (|main_cmds) || mem_wr_adv_o || io_wr_adv_o;
    assign rd_cmd    = mem_rd_o || io_rd_o || irq_ack_o;

    assert_cmd_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(main_cmds));

    assert_passive_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (status_i == 3'b111) |=> (!any_cmd && !addr_strobe_o && !xcvr_en_o));

    assert_ale_single_R2: assert property (@(posedge clk) disable iff (rst)
        addr_strobe_o |=> !addr_strobe_o);

    assert_ale_before_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_cmd) |-> $past(addr_strobe_o));

    assert_adv_before_memwr_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_wr_o) |-> ($past(mem_wr_adv_o) && mem_wr_adv_o));

    assert_adv_before_iowr_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(io_wr_o) |-> ($past(io_wr_adv_o) && io_wr_adv_o));

    assert_adv_with_ale_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_wr_adv_o) || $rose(io_wr_adv_o)) |-> $past(addr_strobe_o));

    assert_read_dir_R9: assert property (@(posedge clk) disable iff (rst)
        rd_cmd |-> !xcvr_tx_o);

    assert_local_ack_R11: assert property (@(posedge clk) disable iff (rst)
        (irq_ack_o && local_irqc_i) |-> !xcvr_en_o);

    assert_en_needs_cmd_R10: assert property (@(posedge clk) disable iff (rst)
        xcvr_en_o |-> any_cmd);

endmodule

bind bcc_top bcc_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .status_i      (status_i),
    .local_irqc_i  (local_irqc_i),
    .addr_strobe_o (addr_strobe_o),
    .xcvr_en_o     (xcvr_en_o),
    .xcvr_tx_o     (xcvr_tx_o),
    .mem_rd_o      (mem_rd_o),
    .mem_wr_o      (mem_wr_o),
    .mem_wr_adv_o  (mem_wr_adv_o),
    .io_rd_o       (io_rd_o),
    .io_wr_o       (io_wr_o),
    .io_wr_adv_o   (io_wr_adv_o),
    .irq_ack_o     (irq_ack_o)
);

// File: tb/bcc_top_tb.sv
module bcc_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] status = 3'b111;
    logic       local_sel = 1'b0;
    logic       ale, en, tx, mrd, mwr, mwa, iord, iowr, iowa, ack;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bcc_top u_dut (
        .clk           (clk),
        .rst           (rst),
        .status_i      (status),
        .local_irqc_i  (local_sel),
        .addr_strobe_o (ale),
        .xcvr_en_o     (en),
        .xcvr_tx_o     (tx),
        .mem_rd_o      (mrd),
        .mem_wr_o      (mwr),
        .mem_wr_adv_o  (mwa),
        .io_rd_o       (iord),
        .io_wr_o       (iowr),
        .io_wr_adv_o   (iowa),
        .irq_ack_o     (ack)
    );

    // Vector order: mem_rd mem_wr mem_wr_adv io_rd io_wr io_wr_adv ack ale en tx
    localparam logic [9:0] IDLE_VEC = 10'b0000000_001;

    function automatic logic [9:0] outs();
        return {mrd, mwr, mwa, iord, iowr, iowa, ack, ale, en, tx};
    endfunction

    // ph: 1 = address clock, 2 = early command clock, 3 = late command clock
    function automatic logic [9:0] expect_vec(logic [2:0] code, int ph, logic lsel);
        logic [9:0] v;
        logic inb;
        v   = '0;
        inb = (code == 3'b000) || (code == 3'b001) || (code == 3'b100) || (code == 3'b101);
        v[0] = !inb;
        if (ph == 1) v[2] = 1'b1;
        if (ph >= 2) begin
            v[1] = !((code == 3'b000) && lsel);
            case (code)
                3'b100, 3'b101: v[9] = 1'b1;
                3'b001:         v[6] = 1'b1;
                3'b000:         v[3] = 1'b1;
                3'b110: begin v[7] = 1'b1; v[8] = (ph == 3); end
                3'b010: begin v[4] = 1'b1; v[5] = (ph == 3); end
                default: ;
            endcase
        end
        return v;
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(string req, logic [9:0] got, logic [9:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic t_reset();
        status = 3'b101;
        tick();
        check("R1 during reset", outs(), IDLE_VEC);
        status = 3'b111;
        rst = 1'b0;
        tick();
        check("R1 after reset", outs(), IDLE_VEC);
    endtask

    task automatic run_cycle(logic [2:0] code, logic lsel, int late_clks, string tag);
        local_sel = lsel;
        status = code;
        tick();
        check({tag, " R2 address clock"}, outs(), expect_vec(code, 1, lsel));
        tick();
        check({tag, " R3/R4 early clock"}, outs(), expect_vec(code, 2, lsel));
        for (int i = 0; i < late_clks; i++) begin
            tick();
            check({tag, " R5 late clock"}, outs(), expect_vec(code, 3, lsel));
        end
        status = 3'b111;
        tick();
        check({tag, " R7 release"}, outs(), IDLE_VEC);
        local_sel = 1'b0;
    endtask

    task automatic t_decode();
        run_cycle(3'b101, 1'b0, 2, "R3 memrd");
        run_cycle(3'b100, 1'b0, 1, "R3 code");
        run_cycle(3'b001, 1'b0, 1, "R3 iord R9");
        run_cycle(3'b110, 1'b0, 2, "R4 R5 memwr");
        run_cycle(3'b010, 1'b0, 2, "R4 R5 iowr");
        run_cycle(3'b000, 1'b0, 1, "R10 ack remote");
        run_cycle(3'b000, 1'b1, 2, "R11 ack local");
    endtask

    task automatic t_halt();
        status = 3'b011;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R6 halt", outs(), IDLE_VEC);
        end
        status = 3'b111;
        tick();
        check("R6 halt release", outs(), IDLE_VEC);
    endtask

    task automatic t_early_passive();
        status = 3'b110;
        tick();
        tick();
        check("R4 early write", outs(), expect_vec(3'b110, 2, 1'b0));
        status = 3'b111;
        tick();
        check("R7 passive beats normal write", outs(), IDLE_VEC);
        tick();
        check("R7 stays idle", outs(), IDLE_VEC);
    endtask

    task automatic t_code_change();
        status = 3'b101;
        tick();
        tick();
        status = 3'b110;
        tick();
        check("R12 latched code kept", outs(), expect_vec(3'b101, 3, 1'b0));
        status = 3'b001;
        tick();
        check("R12 second change ignored", outs(), expect_vec(3'b101, 3, 1'b0));
        status = 3'b111;
        tick();
        check("R12 release", outs(), IDLE_VEC);
    endtask

    task automatic t_back_to_back();
        status = 3'b010;
        tick();
        tick();
        tick();
        status = 3'b111;
        tick();
        check("R7 first cycle released", outs(), IDLE_VEC);
        status = 3'b001;
        tick();
        check("R2 next cycle strobe", outs(), expect_vec(3'b001, 1, 1'b0));
        tick();
        check("R8 single command", {31'd0, $countones({mrd, mwr, iord, iowr, ack}) == 1}, 32'd1);
        status = 3'b111;
        tick();
        check("R9 direction back to transmit", outs(), IDLE_VEC);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_decode();
        t_halt();
        t_early_passive();
        t_code_change();
        t_back_to_back();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule